// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block is the software-facing register file of a simple Ethernet MAC. It sits on a synchronous 16-bit bus with an 8-bit offset. A read returns its data one cycle later, on `bus_rdata`. The block holds the interface, transmit and receive configuration words. It also holds the FIFO control words, the event mask, a set of software-writable statistics counters, the 48-bit station address and a 64-bit multicast hash filter. Every one of these drives the MAC datapath directly through output ports.

Two registers have side effects. The global event status register collects events raised by the datapath and empties itself when software reads it. The peak-attempts register keeps the largest transmit attempt count reported, and it also empties on read. Two bit-bang control registers let software drive the PHY management serial line and the configuration EEPROM serial line. Each time software writes a clock bit that rises relative to the previous write, the block emits a one-cycle strobe carrying the data bit to the matching serial engine. A read of either register returns the bit that engine currently presents.

Top module: `ethmac_ctrl_regs`

## Requirements
- R1: After reset, the event mask (offset 0x04) reads 0xFFFF, global status (0x03) reads 0, peak attempts (0x08) reads 0 and the transmit soft-reset register (0x06) reads 1.
- R2: Each set bit of `evt_set` is ORed into global status in its cycle. A read of 0x03 returns the value held before that access and clears it. An event in the same cycle as the clearing read survives and shows on the next read.
- R3: When `att_valid` is high, peak attempts keeps the larger of its value and `att_count`. A read of 0x08 returns the held 8-bit value zero-extended and clears it. A report in the same cycle as that read becomes the new value.
- R4: In a write to TX FIFO control (0x0D) or RX FIFO control (0x0E), bit 0 drives the enable output and bits 8:1 hold N. The byte-size output is (N+1)*128 from the following cycle.
- R5: A write to the management CSR (0x02) whose bit 0 (clock) is 1 while the previously written bit 0 was 0 raises exactly one one-cycle strobe in the cycle after the write. If bit 2 (output enable) is 1 it is `mdio_tx_stb` with `mdio_bit` = bit 1; otherwise it is `mdio_rx_stb`. The previous value is 0 after reset.
- R6: A read of 0x02 returns the last value written there, with bit 3 replaced by `mdio_in`.
- R7: A write to the EEPROM CSR (0x05) with bit 3 (chip select) clear pulses `ee_rst` for one cycle and raises no strobe. With bit 3 set and bit 0 rising against the previous write, `ee_stb` pulses with `ee_bit` = bit 1. A read returns the last written value with bit 2 replaced by `ee_in`.
- R8: Writing exactly 1 to 0x06 makes it read 0. Other written values leave it unchanged, and it never returns to 1 without reset.
- R9: Offsets 0x6D, 0x7D and 0x8D hold station-address words 2, 1 and 0, so the word index is 8 minus offset bits 7:4. Offsets 0x4E..0x7E hold hash words 0..3, with the index taken from offset bits 5:4. Word k drives bits 16k+15:16k of `station_addr` or `hash_filter`.
- R10: A read of an unimplemented offset returns 0. A write to one changes no register.
- R11: The plain registers read back the last value written: 0x00, 0x04, 0x07, 0x09..0x0C, 0x0F and 0x10..0x16.
- R12: Offset 0x01 reads the `CHIP_ID` parameter (default 0x00C3), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered at the read edge |
| evt_set | input | 16 | Event bits to OR into global status |
| att_valid | input | 1 | Attempt count report valid |
| att_count | input | 8 | Reported transmit attempt count |
| mdio_in | input | 1 | Bit presented by the management engine |
| mdio_tx_stb | output | 1 | Management transmit-bit strobe |
| mdio_rx_stb | output | 1 | Management receive-bit request strobe |
| mdio_bit | output | 1 | Management data bit of last CSR write |
| ee_in | input | 1 | Bit presented by the EEPROM engine |
| ee_stb | output | 1 | EEPROM bit strobe |
| ee_bit | output | 1 | EEPROM data bit of last CSR write |
| ee_rst | output | 1 | EEPROM engine reset pulse |
| evt_mask | output | 16 | Event mask |
| tx_fifo_en | output | 1 | TX FIFO enable |
| tx_fifo_bytes | output | 16 | TX FIFO size in bytes |
| tx_fifo_thresh | output | 16 | TX FIFO threshold |
| rx_fifo_en | output | 1 | RX FIFO enable |
| rx_fifo_bytes | output | 16 | RX FIFO size in bytes |
| tx_cfg | output | 16 | Transmit configuration |
| rx_cfg | output | 16 | Receive configuration |
| xif_cfg | output | 16 | Transceiver interface configuration |
| station_addr | output | 48 | Station address |
| hash_filter | output | 64 | Multicast hash filter |

## Verification
Two collisions are provoked. In the first, a clearing read of global status falls in the same cycle as a new datapath event. In the second, a clearing read of peak attempts falls in the same cycle as a new attempt report. In each case the bench first loads a known value, then drives the new input and the read on the same clock edge. It then checks that the read returned only the old value and that the following read returns only the new one. This shows that the clear did not discard the coincident update and that the update did not leak into the data already returned.

// File: rtl/ethmac_regs_pkg.sv
package ethmac_regs_pkg;
   localparam int FIFO_N_W     = 8;
   localparam int FIFO_UNIT_LG = 7;
   localparam int FIFO_SZ_W    = FIFO_N_W + FIFO_UNIT_LG + 1;
   localparam int PLAIN_N      = 15;
   localparam int PLAIN_IDX_W  = $clog2(PLAIN_N);

   localparam logic [7:0] OFS_CHIP   = 8'h01;
   localparam logic [7:0] OFS_MGMT   = 8'h02;
   localparam logic [7:0] OFS_GSTAT  = 8'h03;
   localparam logic [7:0] OFS_EE     = 8'h05;
   localparam logic [7:0] OFS_TXRST  = 8'h06;
   localparam logic [7:0] OFS_PEAK   = 8'h08;
   localparam logic [7:0] OFS_TXFIFO = 8'h0D;
   localparam logic [7:0] OFS_RXFIFO = 8'h0E;

   localparam int SLOT_XIF  = 0;
   localparam int SLOT_MASK = 1;
   localparam int SLOT_TXC  = 2;
   localparam int SLOT_RXC  = 6;
   localparam int SLOT_THR  = 7;

   typedef struct packed {
      logic                   hit;
      logic [PLAIN_IDX_W-1:0] idx;
   } slot_t;

   function automatic slot_t plain_slot(input logic [7:0] a);
      slot_t s;
      s.hit = 1'b1;
      case (a)
         8'h00:   s.idx = 4'd0;
         8'h04:   s.idx = 4'd1;
         8'h07:   s.idx = 4'd2;
         8'h09:   s.idx = 4'd3;
         8'h0A:   s.idx = 4'd4;
         8'h0B:   s.idx = 4'd5;
         8'h0C:   s.idx = 4'd6;
         8'h0F:   s.idx = 4'd7;
         8'h10:   s.idx = 4'd8;
         8'h11:   s.idx = 4'd9;
         8'h12:   s.idx = 4'd10;
         8'h13:   s.idx = 4'd11;
         8'h14:   s.idx = 4'd12;
         8'h15:   s.idx = 4'd13;
         8'h16:   s.idx = 4'd14;
         default: begin s.hit = 1'b0; s.idx = '0; end
      endcase
      return s;
   endfunction

   function automatic logic [FIFO_SZ_W-1:0] fifo_bytes(input logic [FIFO_N_W-1:0] n);
      logic [FIFO_SZ_W-1:0] t;
      t = FIFO_SZ_W'(n) + FIFO_SZ_W'(1);
      return t << FIFO_UNIT_LG;
   endfunction
endpackage

// File: rtl/ethmac_reg_bank.sv
module ethmac_reg_bank #(
   parameter int N     = 4,
   parameter int W     = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
   parameter logic [N*W-1:0] RST_VEC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wdata,
   output logic [N*W-1:0]   q
);
   initial begin
      assert (N >= 1 && W >= 1) else $error("reg bank needs N and W of at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q[i*W +: W] <= RST_VEC[i*W +: W];
         else if (we && idx == IDX_W'(i))     q[i*W +: W] <= wdata;
      end
   end

   // R9 / R11: a write never aims past the last word
   a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(idx) < N));
endmodule

// File: rtl/ethmac_cor_reg.sv
module ethmac_cor_reg #(
   parameter int W    = 16,
   parameter bit PEAK = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] upd_val,
   output logic [W-1:0] val
);
   logic [W-1:0] base;
   logic [W-1:0] nxt;

   assign base = clr ? '0 : val;

   if (PEAK) begin : g_peak
      always_comb nxt = (upd && upd_val > base) ? upd_val : base;
      // R3: without a clear the peak never drops
      a_r3_peak_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> val >= $past(val));
   end else begin : g_accum
      always_comb nxt = base | (upd ? upd_val : '0);
      // R2: without a clear set bits stay set
      a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (val & $past(val)) == $past(val));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else        val <= nxt;
   end

   // R2 / R3: a clear with no coincident update leaves zero
   a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (!upd || upd_val == '0)) |=> val == '0);
endmodule

// File: rtl/ethmac_bitbang_csr.sv
module ethmac_bitbang_csr #(
   parameter int W         = 16,
   parameter int CLK_BIT   = 0,
   parameter int DOUT_BIT  = 1,
   parameter int IN_BIT    = 3,
   parameter int SEL_BIT   = 2,
   parameter bit SEL_IS_CS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         in_bit,
   output logic [W-1:0] rd_val,
   output logic         stb_a,
   output logic         stb_b,
   output logic         bit_o,
   output logic         eng_rst
);
   initial begin
      assert (CLK_BIT < W && DOUT_BIT < W && IN_BIT < W && SEL_BIT < W)
         else $error("bit-bang field position outside the word");
   end

   logic [W-1:0] prev;
   logic         rise;

   assign rise = we && wdata[CLK_BIT] && !prev[CLK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '0;
         bit_o <= 1'b0;
      end else if (we) begin
         prev  <= wdata;
         bit_o <= wdata[DOUT_BIT];
      end
   end

   if (SEL_IS_CS) begin : g_chip_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stb_a   <= 1'b0;
            eng_rst <= 1'b0;
         end else begin
            stb_a   <= rise && wdata[SEL_BIT];
            eng_rst <= we && !wdata[SEL_BIT];
         end
      end
      assign stb_b = 1'b0;
      // R7: the engine reset and a bit strobe never coincide
      a_r7_reset_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
         !(eng_rst && stb_a));
   end else begin : g_dir_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stb_a <= 1'b0;
            stb_b <= 1'b0;
         end else begin
            stb_a <= rise && wdata[SEL_BIT];
            stb_b <= rise && !wdata[SEL_BIT];
         end
      end
      assign eng_rst = 1'b0;
      // R5: transmit and receive strobes are exclusive
      a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
         !(stb_a && stb_b));
      a_r5_rx_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         stb_b |=> !stb_b);
   end

   always_comb begin
      rd_val         = prev;
      rd_val[IN_BIT] = in_bit;
   end

   // R5 / R7: a strobe lasts one cycle and always follows a write
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      stb_a |=> !stb_a);
   a_r5_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      stb_a |-> $past(we));
endmodule

// File: rtl/ethmac_ctrl_regs.sv
module ethmac_ctrl_regs
   import ethmac_regs_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 16,
   parameter int          STA_WORDS  = 3,
   parameter int          HASH_WORDS = 4,
   parameter int          PEAK_W     = 8,
   parameter logic [15:0] CHIP_ID    = 16'h00C3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [DATA_W-1:0]          evt_set,
   input  logic                       att_valid,
   input  logic [PEAK_W-1:0]          att_count,
   input  logic                       mdio_in,
   output logic                       mdio_tx_stb,
   output logic                       mdio_rx_stb,
   output logic                       mdio_bit,
   input  logic                       ee_in,
   output logic                       ee_stb,
   output logic                       ee_bit,
   output logic                       ee_rst,
   output logic [DATA_W-1:0]          evt_mask,
   output logic                       tx_fifo_en,
   output logic [FIFO_SZ_W-1:0]       tx_fifo_bytes,
   output logic [DATA_W-1:0]          tx_fifo_thresh,
   output logic                       rx_fifo_en,
   output logic [FIFO_SZ_W-1:0]       rx_fifo_bytes,
   output logic [DATA_W-1:0]          tx_cfg,
   output logic [DATA_W-1:0]          rx_cfg,
   output logic [DATA_W-1:0]          xif_cfg,
   output logic [STA_WORDS*DATA_W-1:0]  station_addr,
   output logic [HASH_WORDS*DATA_W-1:0] hash_filter
);
   localparam int FCTL_W   = FIFO_N_W + 1;
   localparam int STA_IW   = $clog2(STA_WORDS);
   localparam int HASH_IW  = $clog2(HASH_WORDS);
   localparam logic [PLAIN_N*DATA_W-1:0] PLAIN_RST =
      (PLAIN_N*DATA_W)'({DATA_W{1'b1}}) << (SLOT_MASK*DATA_W);

   initial begin
      assert (ADDR_W == 8) else $error("offset decode expects an 8-bit offset");
      assert (DATA_W == 16) else $error("register word must be 16 bits");
      assert (STA_WORDS == 3 && HASH_WORDS == 4) else $error("filter word counts fixed by decode");
      assert (PEAK_W <= DATA_W) else $error("peak field wider than the word");
   end

   // ---------------- access decode ----------------
   logic  wr_en, rd_en;
   slot_t psl;
   logic  sta_hit, hash_hit;
   logic [STA_IW-1:0]  sta_idx;
   logic [HASH_IW-1:0] hash_idx;

   assign wr_en    = bus_sel && bus_wr;
   assign rd_en    = bus_sel && !bus_wr;
   assign psl      = plain_slot(bus_addr);
   assign sta_hit  = (bus_addr[3:0] == 4'hD) && (bus_addr[7:4] >= 4'd6) && (bus_addr[7:4] <= 4'd8);
   assign sta_idx  = STA_IW'(4'd8 - bus_addr[7:4]);
   assign hash_hit = (bus_addr[3:0] == 4'hE) && (bus_addr[7:4] >= 4'd4) && (bus_addr[7:4] <= 4'd7);
   assign hash_idx = bus_addr[5:4];

   // ---------------- plain registers ----------------
   logic [PLAIN_N*DATA_W-1:0] plain_q;

   ethmac_reg_bank #(
      .N(PLAIN_N), .W(DATA_W), .IDX_W(PLAIN_IDX_W), .RST_VEC(PLAIN_RST)
   ) plain_i (
      .clk(clk), .rst_n(rst_n), .we(wr_en && psl.hit), .idx(psl.idx),
      .wdata(bus_wdata), .q(plain_q)
   );

   assign xif_cfg        = plain_q[SLOT_XIF*DATA_W  +: DATA_W];
   assign evt_mask       = plain_q[SLOT_MASK*DATA_W +: DATA_W];
   assign tx_cfg         = plain_q[SLOT_TXC*DATA_W  +: DATA_W];
   assign rx_cfg         = plain_q[SLOT_RXC*DATA_W  +: DATA_W];
   assign tx_fifo_thresh = plain_q[SLOT_THR*DATA_W  +: DATA_W];

   // ---------------- filter banks ----------------
   ethmac_reg_bank #(.N(STA_WORDS), .W(DATA_W), .IDX_W(STA_IW)) sta_i (
      .clk(clk), .rst_n(rst_n), .we(wr_en && sta_hit), .idx(sta_idx),
      .wdata(bus_wdata), .q(station_addr)
   );

   ethmac_reg_bank #(.N(HASH_WORDS), .W(DATA_W), .IDX_W(HASH_IW)) hash_i (
      .clk(clk), .rst_n(rst_n), .we(wr_en && hash_hit), .idx(hash_idx),
      .wdata(bus_wdata), .q(hash_filter)
   );

   // ---------------- FIFO control ----------------
   logic [FCTL_W-1:0] txf_q, rxf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txf_q <= '0;
         rxf_q <= '0;
      end else if (wr_en) begin
         if (bus_addr == OFS_TXFIFO) txf_q <= bus_wdata[FCTL_W-1:0];
         if (bus_addr == OFS_RXFIFO) rxf_q <= bus_wdata[FCTL_W-1:0];
      end
   end

   assign tx_fifo_en    = txf_q[0];
   assign rx_fifo_en    = rxf_q[0];
   assign tx_fifo_bytes = fifo_bytes(txf_q[FCTL_W-1:1]);
   assign rx_fifo_bytes = fifo_bytes(rxf_q[FCTL_W-1:1]);

   // ---------------- transmit soft reset ----------------
   logic txrst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                   txrst_q <= 1'b1;
      else if (wr_en && bus_addr == OFS_TXRST && bus_wdata == 16'd1) txrst_q <= 1'b0;
   end

   // R8: the soft-reset flag never re-arms outside reset
   a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(txrst_q));

   // ---------------- clear-on-read registers ----------------
   logic [DATA_W-1:0] gstat_q;
   logic [PEAK_W-1:0] peak_q;

   ethmac_cor_reg #(.W(DATA_W), .PEAK(1'b0)) gstat_i (
      .clk(clk), .rst_n(rst_n), .clr(rd_en && bus_addr == OFS_GSTAT),
      .upd(1'b1), .upd_val(evt_set), .val(gstat_q)
   );

   ethmac_cor_reg #(.W(PEAK_W), .PEAK(1'b1)) peak_i (
      .clk(clk), .rst_n(rst_n), .clr(rd_en && bus_addr == OFS_PEAK),
      .upd(att_valid), .upd_val(att_count), .val(peak_q)
   );

   // ---------------- bit-bang CSRs ----------------
   logic [DATA_W-1:0] mgmt_rd, ee_rd;
   logic              mgmt_unused_rst, ee_unused_b;

   ethmac_bitbang_csr #(
      .W(DATA_W), .CLK_BIT(0), .DOUT_BIT(1), .IN_BIT(3), .SEL_BIT(2), .SEL_IS_CS(1'b0)
   ) mgmt_i (
      .clk(clk), .rst_n(rst_n), .we(wr_en && bus_addr == OFS_MGMT), .wdata(bus_wdata),
      .in_bit(mdio_in), .rd_val(mgmt_rd), .stb_a(mdio_tx_stb), .stb_b(mdio_rx_stb),
      .bit_o(mdio_bit), .eng_rst(mgmt_unused_rst)
   );

   ethmac_bitbang_csr #(
      .W(DATA_W), .CLK_BIT(0), .DOUT_BIT(1), .IN_BIT(2), .SEL_BIT(3), .SEL_IS_CS(1'b1)
   ) ee_i (
      .clk(clk), .rst_n(rst_n), .we(wr_en && bus_addr == OFS_EE), .wdata(bus_wdata),
      .in_bit(ee_in), .rd_val(ee_rd), .stb_a(ee_stb), .stb_b(ee_unused_b),
      .bit_o(ee_bit), .eng_rst(ee_rst)
   );

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_nxt;

   always_comb begin
      rd_nxt = '0;
      if (psl.hit)                   rd_nxt = plain_q[int'(psl.idx)*DATA_W +: DATA_W];
      else if (sta_hit)              rd_nxt = station_addr[int'(sta_idx)*DATA_W +: DATA_W];
      else if (hash_hit)             rd_nxt = hash_filter[int'(hash_idx)*DATA_W +: DATA_W];
      else begin
         case (bus_addr)
            OFS_CHIP:   rd_nxt = CHIP_ID;
            OFS_MGMT:   rd_nxt = mgmt_rd;
            OFS_GSTAT:  rd_nxt = gstat_q;
            OFS_EE:     rd_nxt = ee_rd;
            OFS_TXRST:  rd_nxt = DATA_W'(txrst_q);
            OFS_PEAK:   rd_nxt = DATA_W'(peak_q);
            OFS_TXFIFO: rd_nxt = DATA_W'(txf_q);
            OFS_RXFIFO: rd_nxt = DATA_W'(rxf_q);
            default:    rd_nxt = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_nxt;
   end

   // R12: the identity word is constant at the port
   a_r12_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr == OFS_CHIP) |=> bus_rdata == CHIP_ID);
   // R10: unimplemented offsets read as zero
   a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr[3:0] == 4'hF && bus_addr[7:4] != 4'h0) |=> bus_rdata == '0);
endmodule

// File: tb/ethmac_ctrl_regs_tb.sv
`timescale 1ns/1ps
module ethmac_ctrl_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [15:0] evt_set = '0;
   logic        att_valid = 1'b0;
   logic [7:0]  att_count = '0;
   logic        mdio_in = 1'b0, mdio_tx_stb, mdio_rx_stb, mdio_bit;
   logic        ee_in = 1'b0, ee_stb, ee_bit, ee_rst;
   logic [15:0] evt_mask, tx_fifo_bytes, tx_fifo_thresh, rx_fifo_bytes, tx_cfg, rx_cfg, xif_cfg;
   logic        tx_fifo_en, rx_fifo_en;
   logic [47:0] station_addr;
   logic [63:0] hash_filter;

   int n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   ethmac_ctrl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .att_valid(att_valid),
      .att_count(att_count), .mdio_in(mdio_in), .mdio_tx_stb(mdio_tx_stb),
      .mdio_rx_stb(mdio_rx_stb), .mdio_bit(mdio_bit), .ee_in(ee_in), .ee_stb(ee_stb),
      .ee_bit(ee_bit), .ee_rst(ee_rst), .evt_mask(evt_mask), .tx_fifo_en(tx_fifo_en),
      .tx_fifo_bytes(tx_fifo_bytes), .tx_fifo_thresh(tx_fifo_thresh), .rx_fifo_en(rx_fifo_en),
      .rx_fifo_bytes(rx_fifo_bytes), .tx_cfg(tx_cfg), .rx_cfg(rx_cfg), .xif_cfg(xif_cfg),
      .station_addr(station_addr), .hash_filter(hash_filter)
   );

   // fields: req[45:42] chk[41] wr[40] addr[39:32] wdata[31:16] exp[15:0]
   localparam int NV = 30;
   localparam logic [45:0] VEC [NV] = '{
      {4'd1,  1'b1, 1'b0, 8'h04, 16'h0000, 16'hFFFF},  // R1 mask
      {4'd1,  1'b1, 1'b0, 8'h03, 16'h0000, 16'h0000},  // R1 status
      {4'd1,  1'b1, 1'b0, 8'h08, 16'h0000, 16'h0000},  // R1 peak
      {4'd8,  1'b1, 1'b0, 8'h06, 16'h0000, 16'h0001},  // R8 armed
      {4'd8,  1'b0, 1'b1, 8'h06, 16'h0002, 16'h0000},  // R8 other value
      {4'd8,  1'b1, 1'b0, 8'h06, 16'h0000, 16'h0001},  // R8 unchanged
      {4'd8,  1'b0, 1'b1, 8'h06, 16'h0001, 16'h0000},  // R8 acknowledge
      {4'd8,  1'b1, 1'b0, 8'h06, 16'h0000, 16'h0000},  // R8 reads 0
      {4'd11, 1'b0, 1'b1, 8'h04, 16'h1234, 16'h0000},  // R11
      {4'd11, 1'b1, 1'b0, 8'h04, 16'h0000, 16'h1234},  // R11
      {4'd11, 1'b0, 1'b1, 8'h13, 16'hBEEF, 16'h0000},  // R11 counter
      {4'd11, 1'b1, 1'b0, 8'h13, 16'h0000, 16'hBEEF},  // R11
      {4'd11, 1'b0, 1'b1, 8'h0C, 16'h0A5A, 16'h0000},  // R11 rx cfg
      {4'd11, 1'b1, 1'b0, 8'h0C, 16'h0000, 16'h0A5A},  // R11
      {4'd12, 1'b0, 1'b1, 8'h01, 16'h5555, 16'h0000},  // R12 write ignored
      {4'd12, 1'b1, 1'b0, 8'h01, 16'h0000, 16'h00C3},  // R12
      {4'd10, 1'b0, 1'b1, 8'h3F, 16'hAAAA, 16'h0000},  // R10 hole write
      {4'd10, 1'b1, 1'b0, 8'h3F, 16'h0000, 16'h0000},  // R10
      {4'd10, 1'b1, 1'b0, 8'h9D, 16'h0000, 16'h0000},  // R10
      {4'd10, 1'b1, 1'b0, 8'h04, 16'h0000, 16'h1234},  // R10 mask untouched
      {4'd9,  1'b0, 1'b1, 8'h6D, 16'h1111, 16'h0000},  // R9
      {4'd9,  1'b0, 1'b1, 8'h7D, 16'h2222, 16'h0000},  // R9
      {4'd9,  1'b0, 1'b1, 8'h8D, 16'h3333, 16'h0000},  // R9
      {4'd9,  1'b1, 1'b0, 8'h7D, 16'h0000, 16'h2222},  // R9
      {4'd9,  1'b0, 1'b1, 8'h4E, 16'hA0A0, 16'h0000},  // R9
      {4'd9,  1'b0, 1'b1, 8'h5E, 16'hB1B1, 16'h0000},  // R9
      {4'd9,  1'b0, 1'b1, 8'h6E, 16'hC2C2, 16'h0000},  // R9
      {4'd9,  1'b0, 1'b1, 8'h7E, 16'hD3D3, 16'h0000},  // R9
      {4'd9,  1'b1, 1'b0, 8'h5E, 16'h0000, 16'hB1B1},  // R9
      {4'd10, 1'b1, 1'b0, 8'h3E, 16'h0000, 16'h0000}   // R10 not hash
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns 1 ns after the next rising edge
   task automatic op(input logic wr, input logic [7:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0; att_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired before R1..R12 sequence finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 no strobe at reset", {mdio_tx_stb, mdio_rx_stb, ee_stb, ee_rst}, 0);

      for (int i = 0; i < NV; i++) begin
         op(VEC[i][40], VEC[i][39:32], VEC[i][31:16]);
         if (VEC[i][41]) begin
            n_cmp++;
            if (bus_rdata !== VEC[i][15:0]) begin
               n_bad++;
               $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                        VEC[i][45:42], i, bus_rdata, VEC[i][15:0]);
            end
         end
         idle();
      end
      chk("R9 station words", station_addr, 64'h1111_2222_3333);
      chk("R9 hash words", hash_filter, 64'hD3D3_C2C2_B1B1_A0A0);

      // R4 FIFO control
      op(1'b1, 8'h0D, 16'h0007); idle();
      chk("R4 tx enable", tx_fifo_en, 1);
      chk("R4 tx bytes N=3", tx_fifo_bytes, 512);
      op(1'b1, 8'h0E, 16'h01FE); idle();
      chk("R4 rx enable", rx_fifo_en, 0);
      chk("R4 rx bytes N=255", rx_fifo_bytes, 32768);
      op(1'b1, 8'h0D, 16'h0000); idle();
      chk("R4 tx bytes N=0", tx_fifo_bytes, 128);

      // R2 global status
      evt_set = 16'h0005; @(negedge clk);
      evt_set = 16'h0100; @(negedge clk);
      evt_set = 16'h0000;
      op(1'b0, 8'h03, 0); chk("R2 accumulated", bus_rdata, 16'h0105); idle();
      op(1'b0, 8'h03, 0); chk("R2 cleared", bus_rdata, 0); idle();
      evt_set = 16'h0003; @(negedge clk);
      evt_set = 16'h0040;
      op(1'b0, 8'h03, 0); chk("R2 read during event", bus_rdata, 16'h0003); idle();
      op(1'b0, 8'h03, 0); chk("R2 event survives clear", bus_rdata, 16'h0040); idle();

      // R3 peak attempts
      att_valid = 1'b1; att_count = 8'd5; @(negedge clk);
      att_count = 8'd3; @(negedge clk);
      att_count = 8'd9; @(negedge clk);
      att_valid = 1'b0;
      op(1'b0, 8'h08, 0); chk("R3 peak", bus_rdata, 9); idle();
      op(1'b0, 8'h08, 0); chk("R3 cleared", bus_rdata, 0); idle();
      att_valid = 1'b1; att_count = 8'd7; @(negedge clk);
      att_count = 8'd4;
      op(1'b0, 8'h08, 0); chk("R3 read during report", bus_rdata, 7); idle();
      op(1'b0, 8'h08, 0); chk("R3 report survives clear", bus_rdata, 4); idle();

      // R5 management strobes
      op(1'b1, 8'h02, 16'h0007);
      chk("R5 tx strobe", {mdio_tx_stb, mdio_rx_stb, mdio_bit}, 3'b101);
      idle();
      op(1'b1, 8'h02, 16'h0005);
      chk("R5 clock held high, no strobe", {mdio_tx_stb, mdio_rx_stb}, 0);
      idle();
      op(1'b1, 8'h02, 16'h0004);
      chk("R5 falling clock, no strobe", {mdio_tx_stb, mdio_rx_stb}, 0);
      idle();
      op(1'b1, 8'h02, 16'h0001);
      chk("R5 rx strobe", {mdio_tx_stb, mdio_rx_stb}, 2'b01);
      idle();
      @(posedge clk); #1;
      chk("R5 strobe one cycle", {mdio_tx_stb, mdio_rx_stb}, 0);
      @(negedge clk);

      // R6 management readback
      mdio_in = 1'b1;
      op(1'b0, 8'h02, 0); chk("R6 input bit 1", bus_rdata, 16'h0009); idle();
      mdio_in = 1'b0;
      op(1'b0, 8'h02, 0); chk("R6 input bit 0", bus_rdata, 16'h0001); idle();

      // R7 EEPROM CSR
      op(1'b1, 8'h05, 16'h0009);
      chk("R7 strobe bit 0", {ee_stb, ee_bit, ee_rst}, 3'b100);
      idle();
      op(1'b1, 8'h05, 16'h0008);
      chk("R7 clock low, no strobe", ee_stb, 0);
      idle();
      op(1'b1, 8'h05, 16'h000B);
      chk("R7 strobe bit 1", {ee_stb, ee_bit, ee_rst}, 3'b110);
      idle();
      op(1'b1, 8'h05, 16'h0003);
      chk("R7 deselect resets engine", {ee_stb, ee_rst}, 2'b01);
      idle();
      ee_in = 1'b1;
      op(1'b0, 8'h05, 0); chk("R7 input bit", bus_rdata, 16'h0007); idle();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule